// File: doc/BRIEF.md
# Critical-Word-First Burst Beat Sequencer

This block steps a 32-byte cache-line transfer across a 32-bit data path. The line is four 64-bit double words. The transfer is split into eight word beats, and the double word that holds the requested data goes first. After a burst request is accepted, the block reports three things on each beat: the double word being moved, whether it is the upper or the lower word of that double word, and the beat number. It also produces the 8-lane byte enables that belong to that beat. The double words wrap modulo four from the starting one. Each double word takes two beats, with the upper word first.

The same block also handles single-beat transfers of one byte or one half word. For these it decodes the size code and the low address bits into byte-lane enables. A request it cannot perform is refused with a one-cycle error pulse. This covers a burst whose byte offset is not zero, a half word on an odd lane, and any other size code. The data-acknowledge input paces the beats. A done pulse marks the cycle in which the last beat is acknowledged.

Top module: `cwf_beat_seq`

## Requirements
- R1: A burst request (`req_valid`=1, `req_burst`=1) is accepted only when the block is idle and `req_addr[2:0]`=0. From the next cycle `beat_valid` is high for exactly eight acknowledged beats, and `beat_cnt` runs from 0 to 7.
- R2: The first double word of a burst is `req_addr[4:3]`. For beat k, `beat_dw` is (`req_addr[4:3]` + k/2) mod 4. A start at 2 therefore gives the order 2,3,0,1.
- R3: Within each double word, the upper word comes first (`beat_lower`=0, even k) and the lower word comes second (`beat_lower`=1, odd k).
- R4: During a burst, `lane_en` is 8'h0F on an upper-word beat (lanes 0 to 3) and 8'hF0 on a lower-word beat (lanes 4 to 7). Lane n is bit n of `lane_en`.
- R5: The block advances by one beat on each cycle in which `ack` is high. While `ack` is low, every beat output holds its value.
- R6: `done` is high only in the cycle in which the final beat is acknowledged. In the next cycle the block is idle (`beat_valid`=0, `lane_en`=0).
- R7: A request that arrives while a transfer is in progress has no effect on the beat order, and it is not remembered after the transfer ends.
- R8: A burst request with `req_addr[2:0]` not equal to 0 starts no transfer and raises `proto_err` for exactly one cycle, in the cycle after the request.
- R9: A single byte transfer (`req_burst`=0, `req_size`=3'b001) is legal at every offset. It gives one beat with `lane_en` = 1 << `req_addr[2:0]`, `beat_cnt`=0, `beat_dw`=`req_addr[4:3]` and `beat_lower`=`req_addr[2]`. `done` is raised when that beat is acknowledged.
- R10: A half-word transfer (`req_size`=3'b010) at an even offset n gives one beat with lanes n and n+1 enabled. At an odd offset it is refused as in R8.
- R11: A single transfer with any other size code is refused as in R8.
- R12: After reset the block is idle, and `beat_valid`, `lane_en`, `done` and `proto_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_burst | input | 1 | 1 = eight-beat line burst, 0 = single beat |
| req_size | input | 3 | Single-beat size code: 001 byte, 010 half word |
| req_addr | input | 5 | Line offset: [4:3] double word, [2:0] byte lane |
| ack | input | 1 | Data acknowledge; accepts the current beat |
| beat_valid | output | 1 | A beat is presented |
| beat_dw | output | 2 | Double-word index of the current beat |
| beat_lower | output | 1 | 0 = upper word, 1 = lower word |
| beat_cnt | output | 3 | Beat number within the burst |
| lane_en | output | 8 | Byte-lane enables of the current beat |
| done | output | 1 | Final beat acknowledged this cycle |
| proto_err | output | 1 | One-cycle pulse for a refused request |

## Verification
The hardest situation to reach from the ports is a new request that arrives in the middle of a stalled burst. To show that it is ignored, the wrapped order has to carry on unchanged and the block has to come back idle afterwards. The directed runs hold `req_valid` high, with a different starting double word, from the fourth beat until done. They do this while `ack` is dropped at random. Random runs then mix all four starting double words, every byte offset and illegal size codes, all with random stall patterns.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_BURST  = 2'd1,
        MODE_SINGLE = 2'd2
    } mode_e;

    localparam logic [2:0] SIZE_BYTE = 3'b001;
    localparam logic [2:0] SIZE_HALF = 3'b010;
endpackage

// File: rtl/cwf_order_gen.sv
// Maps a start double word and a beat number onto the wrapped
// double-word index, the word half and the burst lane mask.
module cwf_order_gen #(
    parameter  int DW_COUNT = 4,
    parameter  int LANES    = 8,
    localparam int DW_W     = $clog2(DW_COUNT),
    localparam int CNT_W    = DW_W + 1
) (
    input  logic [DW_W-1:0]  start_dw,
    input  logic [CNT_W-1:0] cnt,
    output logic [DW_W-1:0]  dw,
    output logic             lower,
    output logic [LANES-1:0] word_mask
);
    localparam int HALF_LANES = LANES / 2;

    assign lower = cnt[0];
    assign dw    = start_dw + cnt[CNT_W-1:1];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < HALF_LANES) begin : g_up
            assign word_mask[i] = ~lower;
        end else begin : g_lo
            assign word_mask[i] = lower;
        end
    end
endmodule

// File: rtl/cwf_lane_decode.sv
// Decodes a single-beat size code and byte offset into lane enables.
module cwf_lane_decode #(
    parameter  int LANES = 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [2:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic [LANES-1:0] mask,
    output logic             legal
);
    import cwf_pkg::*;

    always_comb begin
        mask  = '0;
        legal = 1'b0;
        case (size)
            SIZE_BYTE: begin
                mask  = LANES'(1) << off;
                legal = 1'b1;
            end
            SIZE_HALF: begin
                if (!off[0]) begin
                    mask  = LANES'(3) << off;
                    legal = 1'b1;
                end
            end
            default: begin
                mask  = '0;
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq #(
    parameter  int DW_COUNT = 4,
    parameter  int LANES    = 8,
    localparam int DW_W     = $clog2(DW_COUNT),
    localparam int OFF_W    = $clog2(LANES),
    localparam int ADDR_W   = DW_W + OFF_W,
    localparam int CNT_W    = DW_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_burst,
    input  logic [2:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              ack,
    output logic              beat_valid,
    output logic [DW_W-1:0]   beat_dw,
    output logic              beat_lower,
    output logic [CNT_W-1:0]  beat_cnt,
    output logic [LANES-1:0]  lane_en,
    output logic              done,
    output logic              proto_err
);
    import cwf_pkg::*;

    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(2 * DW_COUNT - 1);

    typedef struct packed {
        mode_e            mode;
        logic [DW_W-1:0]  start_dw;
        logic [CNT_W-1:0] cnt;
        logic [LANES-1:0] lanes;
        logic             err;
    } seq_t;

    seq_t st_d, st_q;

    logic [DW_W-1:0]  gen_dw;
    logic             gen_lower;
    logic [LANES-1:0] gen_mask;
    logic [LANES-1:0] dec_mask;
    logic             dec_legal;
    logic [OFF_W-1:0] req_off;
    logic [DW_W-1:0]  req_dw;

    assign req_off = req_addr[OFF_W-1:0];
    assign req_dw  = req_addr[ADDR_W-1:OFF_W];

    cwf_order_gen #(.DW_COUNT(DW_COUNT), .LANES(LANES)) u_order (
        .start_dw  (st_q.start_dw),
        .cnt       (st_q.cnt),
        .dw        (gen_dw),
        .lower     (gen_lower),
        .word_mask (gen_mask)
    );

    cwf_lane_decode #(.LANES(LANES)) u_decode (
        .size  (req_size),
        .off   (req_off),
        .mask  (dec_mask),
        .legal (dec_legal)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        case (st_q.mode)
            MODE_IDLE: begin
                if (req_valid) begin
                    if (req_burst) begin
                        if (req_off == '0) begin
                            st_d.mode     = MODE_BURST;
                            st_d.start_dw = req_dw;
                            st_d.cnt      = '0;
                            st_d.lanes    = '0;
                        end else begin
                            st_d.err = 1'b1;
                        end
                    end else if (dec_legal) begin
                        st_d.mode     = MODE_SINGLE;
                        st_d.start_dw = req_dw;
                        st_d.cnt      = {{(CNT_W-1){1'b0}}, req_off[OFF_W-1]};
                        st_d.lanes    = dec_mask;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
            end
            MODE_BURST: begin
                if (ack) begin
                    if (st_q.cnt == LAST_BEAT) begin
                        st_d.mode = MODE_IDLE;
                        st_d.cnt  = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            MODE_SINGLE: begin
                if (ack) begin
                    st_d.mode = MODE_IDLE;
                    st_d.cnt  = '0;
                end
            end
            default: st_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_IDLE, start_dw: '0, cnt: '0, lanes: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_valid = (st_q.mode != MODE_IDLE);
    assign beat_dw    = beat_valid ? gen_dw : '0;
    assign beat_lower = beat_valid ? gen_lower : 1'b0;
    assign beat_cnt   = (st_q.mode == MODE_BURST) ? st_q.cnt : '0;
    assign lane_en    = (st_q.mode == MODE_BURST)  ? gen_mask :
                        (st_q.mode == MODE_SINGLE) ? st_q.lanes : '0;
    assign done       = ack && (((st_q.mode == MODE_BURST) && (st_q.cnt == LAST_BEAT))
                                || (st_q.mode == MODE_SINGLE));
    assign proto_err  = st_q.err;

    // R5: a stalled beat keeps its position
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !ack) |=> (beat_valid && $stable(beat_cnt) && $stable(beat_dw)
                                  && $stable(lane_en)));

    // R2, R3: an accepted upper-word beat moves to the lower word of the same double word
    assert_wrap_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_BURST && ack && !beat_lower && beat_cnt != LAST_BEAT)
        |=> (beat_lower && beat_dw == $past(beat_dw)));

    // R2: an accepted lower-word beat moves on to the next double word, wrapping
    assert_next_dw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_BURST && ack && beat_lower && beat_cnt != LAST_BEAT)
        |=> (!beat_lower && beat_dw == DW_W'($past(beat_dw) + 1'b1)));

    // R4: burst lanes are one whole word
    assert_burst_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_BURST) |-> ($countones(lane_en) == LANES / 2));

    // R6: done leaves the block idle
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !beat_valid);

    // R1: every transfer starts at beat zero
    assert_start_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid) |-> (beat_cnt == '0));

    // R8: a refused request starts nothing
    assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (!beat_valid && lane_en == '0));
endmodule

// File: tb/cwf_beat_seq_bench.sv
module cwf_beat_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_burst = 1'b0;
    logic [2:0] req_size = '0;
    logic [4:0] req_addr = '0;
    logic       ack = 1'b0;
    logic       beat_valid;
    logic [1:0] beat_dw;
    logic       beat_lower;
    logic [2:0] beat_cnt;
    logic [7:0] lane_en;
    logic       done;
    logic       proto_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    cwf_beat_seq u_cwf_beat_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
        .req_size(req_size), .req_addr(req_addr), .ack(ack),
        .beat_valid(beat_valid), .beat_dw(beat_dw), .beat_lower(beat_lower),
        .beat_cnt(beat_cnt), .lane_en(lane_en), .done(done), .proto_err(proto_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_single_lanes(input logic [2:0] size, input logic [2:0] off);
        if (size == 3'b001) return 8'(1) << off;
        if (size == 3'b010 && !off[0]) return 8'(3) << off;
        return 8'h00;
    endfunction

    function automatic bit single_legal(input logic [2:0] size, input logic [2:0] off);
        return (size == 3'b001) || (size == 3'b010 && !off[0]);
    endfunction

    // Called at a negedge with the refused request already presented
    task automatic expect_refusal(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check({tag, " err pulse"}, proto_err, 1);
        check({tag, " no beat"}, beat_valid, 0);
        @(negedge clk);
        #1;
        check({tag, " err one cycle"}, proto_err, 0);
        check({tag, " still idle"}, beat_valid, 0);
    endtask

    task automatic run_burst(input logic [4:0] addr, input int stall_pct, input bit intrude);
        int  k = 0;
        bit  a;
        bit  stalled = 0;
        req_valid = 1'b1;
        req_burst = 1'b1;
        req_size  = 3'($urandom);
        req_addr  = addr;
        if (addr[2:0] != 3'b000) begin
            expect_refusal("R8 burst offset");
            return;
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (k < 8) begin
            #1;
            check("R1 beat valid", beat_valid, 1);
            check(stalled ? "R5 cnt hold" : "R1 cnt", beat_cnt, k);
            check("R2 dw order", beat_dw, 2'(addr[4:3] + k / 2));
            check("R3 word half", beat_lower, k % 2);
            check("R4 burst lanes", lane_en, (k % 2) ? 8'hF0 : 8'h0F);
            if (intrude && k == 3) begin
                req_valid = 1'b1;
                req_burst = 1'b1;
                req_addr  = {2'(addr[4:3] + 2'd1), 3'b000};
            end
            a   = (32'($urandom % 100) >= 32'(stall_pct));
            ack = a;
            #1;
            check("R6 done timing", done, (a && k == 7) ? 1 : 0);
            @(negedge clk);
            stalled = !a;
            if (a) k++;
        end
        ack       = 1'b0;
        req_valid = 1'b0;
        #1;
        check(intrude ? "R7 ignored request" : "R6 idle after done", beat_valid, 0);
        check("R6 lanes idle", lane_en, 0);
    endtask

    task automatic run_single(input logic [2:0] size, input logic [4:0] addr, input int stalls);
        string tag;
        tag = (size == 3'b001) ? "R9" : (size == 3'b010) ? "R10" : "R11";
        req_valid = 1'b1;
        req_burst = 1'b0;
        req_size  = size;
        req_addr  = addr;
        if (!single_legal(size, addr[2:0])) begin
            expect_refusal({tag, " refused"});
            return;
        end
        @(negedge clk);
        req_valid = 1'b0;
        for (int s = 0; s <= stalls; s++) begin
            #1;
            check({tag, " beat valid"}, beat_valid, 1);
            check({tag, " lanes"}, lane_en, exp_single_lanes(size, addr[2:0]));
            check({tag, " dw"}, beat_dw, addr[4:3]);
            check({tag, " half"}, beat_lower, addr[2]);
            check({tag, " cnt"}, beat_cnt, 0);
            if (s < stalls) begin
                ack = 1'b0;
                #1;
                check("R5 single hold", done, 0);
                @(negedge clk);
            end
        end
        ack = 1'b1;
        #1;
        check({tag, " done"}, done, 1);
        @(negedge clk);
        ack = 1'b0;
        #1;
        check({tag, " idle after"}, beat_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check("R12 reset valid", beat_valid, 0);
        check("R12 reset lanes", lane_en, 0);
        check("R12 reset done", done, 0);
        check("R12 reset err", proto_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: every start double word without stalls, then with stalls and intrusion
        for (int d = 0; d < 4; d++) run_burst({2'(d), 3'b000}, 0, 1'b0);
        run_burst(5'b10_000, 50, 1'b1);
        run_burst(5'b11_000, 70, 1'b1);
        run_burst(5'b01_100, 0, 1'b0);
        run_single(3'b001, 5'b11_111, 2);
        run_single(3'b010, 5'b00_110, 0);
        run_single(3'b010, 5'b01_011, 0);
        run_single(3'b100, 5'b00_000, 0);
        run_single(3'b000, 5'b00_000, 0);

        // Random mix
        for (int n = 0; n < 150; n++) begin
            logic [4:0] a5;
            int sel;
            a5  = 5'($urandom);
            sel = int'($urandom % 5);
            case (sel)
                0: run_burst({a5[4:3], 3'b000}, int'($urandom % 60), 1'($urandom));
                1: run_burst(a5, 20, 1'b0);
                2: run_single(3'b001, a5, int'($urandom % 3));
                3: run_single(3'b010, a5, int'($urandom % 3));
                default: run_single(3'($urandom), a5, int'($urandom % 2));
            endcase
            repeat (int'($urandom % 2)) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule